// File: doc/BRIEF.md
# Prioritized Two-Source Interrupt Controller

This block decides when a processor core enters an interrupt routine. It watches two external request pins and one timer request line. Each pin goes through a synchronizer and then a rising-edge detector. Each pin also has its own mask flag, which arms itself on the same edge that raised the request. Any further activity on that pin is then ignored until software clears the flag. Requests from either pin merge into one pin-request latch. The timer pulse has its own latch.

A global enable flag gates entry into an interrupt. While the flag is set and any latch is pending, the block raises a one-cycle entry strobe together with a vector address. The pin source outranks the timer. At the clock edge that ends the strobe, the served latch and the global enable both clear. A pending timer request that lost arbitration stays latched. It is served once the return strobe has restored the enable.

Software sees the two mask flags, the two synchronized pin levels and the enable flag. The pins can therefore also act as latched general inputs. The core and the return-address stack live outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset leaves both mask flags at 1, both request latches empty, the global enable at 0 and the entry strobe at 0. Logic leaves reset on the second clock edge after `rst_n` is released.
- R2: A rising edge on an unmasked pin is sampled through two synchronizer flops. At the third clock edge after the pin changes, it sets the pin-request latch and that pin's mask flag at the same time.
- R3: While a pin's mask flag is 1, edges on that pin create no request. A flag stays 1 until a one-cycle pulse on its own `mask_clr_i` bit clears it at the next edge.
- R4: A falling edge or a steady level on a pin creates no request.
- R5: `take_o` is 1 in every cycle in which the global enable is 1 and any latch is pending. At the following edge the served latch clears and the global enable drops to 0.
- R6: With the global enable at 0, a pending request stays latched. It is taken in the cycle after `ie_set_i` or `ret_i` restores the enable.
- R7: When both latches are pending, the pin request is served first. The timer latch stays at 1 and is taken after the next return strobe.
- R8: During `take_o`, `vec_o` is {page, offset}, with a 4-bit page above a 6-bit offset of all ones. It is 0x07F (page 1) for a pin request and 0x03F (page 0) for a timer request.
- R9: A pulse on `ret_i` or `ie_set_i` sets the global enable at the next edge, unless an entry is taken at that edge.
- R10: `pin_lvl_o` shows each pin's level two clock edges after it changes. `mask_o` shows the mask flags, with bit i belonging to pin i.
- R11: A one-cycle pulse on `timer_req_i` sets the timer latch at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | External request pins, asynchronous |
| timer_req_i | input | 1 | Timer request pulse |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ie_set_i | input | 1 | Software write that sets the global enable |
| mask_clr_i | input | 2 | Per-pin mask clear pulses |
| take_o | output | 1 | Interrupt entry strobe |
| vec_o | output | 10 | Entry vector address {page, offset} |
| ie_o | output | 1 | Global enable readback |
| mask_o | output | 2 | Mask flag readback |
| pin_lvl_o | output | 2 | Synchronized pin level readback |

## Verification
The results arrive at different depths. A pin change shows on `pin_lvl_o` after two edges and reaches the latch and mask at the third. With the enable set, `take_o` follows right after that edge. A timer pulse is latched after one edge. Return, enable and mask-clear pulses act at the next edge. The bench drives inputs on falling edges and moves a behavioural model at each rising edge. It compares every output at the falling edge that follows, so each result is judged in the exact cycle its latency says it is due. Directed counts of taken entries, split by vector, confirm masking, holding and priority over whole scenarios.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Source selected by the arbiter in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_TIMER = 2'd2
  } irq_src_e;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_pin_unit.sv
module irqc_pin_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic mask_clr_i,
  output logic level_o,
  output logic mask_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   mask_q;
  logic                   mask_d;
  logic                   level;
  logic                   rise;

  // Synchronizer chain: stage 0 samples the pin
  always_comb begin
    sync_d[0] = pin_i;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_comb begin
        sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  assign level = sync_q[SYNC_STAGES-1];

  // Leading-edge pulse only while the pin is unmasked
  always_comb begin
    rise   = level & ~prev_q & ~mask_q;
    prev_d = level;
    mask_d = rise | (mask_q & ~mask_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      mask_q <= mask_d;
    end
  end

  assign level_o = level;
  assign mask_o  = mask_q;
  assign rise_o  = rise;

  // The edge that raises a request also arms the mask
  assert_mask_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> mask_q);

  // A set mask only leaves through a clear pulse
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !mask_clr_i) |=> mask_q);

endmodule

// File: rtl/irqc_req_latch.sv
module irqc_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // A new request in the serving cycle wins over the clear
  always_comb begin
    pend_d = set_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irqc_entry_ctrl.sv
module irqc_entry_ctrl
  import irqc_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int OFS_W     = 6,
  parameter int PIN_PAGE  = 1,
  parameter int TMR_PAGE  = 0,
  localparam int VEC_W    = PAGE_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_pend_i,
  input  logic             tmr_pend_i,
  input  logic             ret_i,
  input  logic             ie_set_i,
  output logic             take_o,
  output logic             clr_pin_o,
  output logic             clr_tmr_o,
  output logic             ie_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam logic [PAGE_W-1:0] PIN_PG = PIN_PAGE[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] TMR_PG = TMR_PAGE[PAGE_W-1:0];
  localparam logic [VEC_W-1:0]  PIN_VEC = {PIN_PG, {OFS_W{1'b1}}};
  localparam logic [VEC_W-1:0]  TMR_VEC = {TMR_PG, {OFS_W{1'b1}}};

  logic     ie_q;
  logic     ie_d;
  logic     take;
  irq_src_e src;

  // Fixed priority: pin source ahead of timer
  always_comb begin
    if (pin_pend_i) begin
      src = SRC_PIN;
    end else if (tmr_pend_i) begin
      src = SRC_TIMER;
    end else begin
      src = SRC_NONE;
    end
  end

  always_comb begin
    take      = ie_q & (src != SRC_NONE);
    clr_pin_o = take & (src == SRC_PIN);
    clr_tmr_o = take & (src == SRC_TIMER);
    vec_o     = (src == SRC_PIN) ? PIN_VEC : TMR_VEC;
  end

  // Entry drops the enable; return or software write restores it
  always_comb begin
    ie_d = ie_q;
    if (take) begin
      ie_d = 1'b0;
    end else if (ret_i || ie_set_i) begin
      ie_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else begin
      ie_q <= ie_d;
    end
  end

  assign take_o = take;
  assign ie_o   = ie_q;

  assert_entry_drops_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie_q);

  assert_return_sets_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_i || ie_set_i) && !take) |=> ie_q);

  assert_no_entry_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !take);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NPINS       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int PAGE_W      = 4,
  parameter int OFS_W       = 6,
  localparam int VEC_W      = PAGE_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] ext_pin_i,
  input  logic             timer_req_i,
  input  logic             ret_i,
  input  logic             ie_set_i,
  input  logic [NPINS-1:0] mask_clr_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ie_o,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] pin_lvl_o
);

  logic             rst_n_s;
  logic [NPINS-1:0] rise;
  logic             any_rise;
  logic             pin_pend;
  logic             tmr_pend;
  logic             clr_pin;
  logic             clr_tmr;
  logic             take;

  irqc_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      irqc_pin_unit #(.SYNC_STAGES(SYNC_STAGES)) i_pin (
        .clk        (clk),
        .rst_n      (rst_n_s),
        .pin_i      (ext_pin_i[p]),
        .mask_clr_i (mask_clr_i[p]),
        .level_o    (pin_lvl_o[p]),
        .mask_o     (mask_o[p]),
        .rise_o     (rise[p])
      );
    end
  endgenerate

  assign any_rise = |rise;

  irqc_req_latch i_pin_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (any_rise),
    .clr_i  (clr_pin),
    .pend_o (pin_pend)
  );

  irqc_req_latch i_tmr_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (timer_req_i),
    .clr_i  (clr_tmr),
    .pend_o (tmr_pend)
  );

  irqc_entry_ctrl #(
    .PAGE_W   (PAGE_W),
    .OFS_W    (OFS_W),
    .PIN_PAGE (1),
    .TMR_PAGE (0)
  ) i_entry (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pin_pend_i (pin_pend),
    .tmr_pend_i (tmr_pend),
    .ret_i      (ret_i),
    .ie_set_i   (ie_set_i),
    .take_o     (take),
    .clr_pin_o  (clr_pin),
    .clr_tmr_o  (clr_tmr),
    .ie_o       (ie_o),
    .vec_o      (vec_o)
  );

  assign take_o = take;

  // Lost arbitration keeps the timer request
  assert_timer_waits_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pin_pend && tmr_pend && take) |=> tmr_pend);

  // Disabled state holds a pending pin request
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ie_o && pin_pend) |=> pin_pend);

  assert_timer_capture_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    timer_req_i |=> tmr_pend);

  assert_pin_capture_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    any_rise |=> pin_pend);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin = '0;
  logic       timer_req = 1'b0;
  logic       ret = 1'b0;
  logic       ie_set = 1'b0;
  logic [1:0] mask_clr = '0;
  logic       take;
  logic [9:0] vec;
  logic       ie;
  logic [1:0] mask;
  logic [1:0] pin_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  int n_in    = 0;
  int n_tm    = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_pin_i   (ext_pin),
    .timer_req_i (timer_req),
    .ret_i       (ret),
    .ie_set_i    (ie_set),
    .mask_clr_i  (mask_clr),
    .take_o      (take),
    .vec_o       (vec),
    .ie_o        (ie),
    .mask_o      (mask),
    .pin_lvl_o   (pin_lvl)
  );

  // Behavioural reference: pin histories, request flags, enable
  int hist [2][$];
  int m_mask [2];
  int m_prev [2];
  int m_in, m_tm, m_ie;
  int rs1, rs2;

  function automatic void model_reset();
    for (int p = 0; p < 2; p++) begin
      hist[p] = '{0, 0};
      m_mask[p] = 1;
      m_prev[p] = 0;
    end
    m_in = 0; m_tm = 0; m_ie = 0;
  endfunction

  initial begin
    model_reset();
    rs1 = 0; rs2 = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0;
      model_reset();
    end else begin
      if (!rs2) begin
        model_reset();
      end else begin
        int lvl [2];
        int edge_seen;
        int entry;
        edge_seen = 0;
        entry = (m_ie != 0) && (m_in != 0 || m_tm != 0);
        for (int p = 0; p < 2; p++) begin
          lvl[p] = hist[p][1];
          if (lvl[p] == 1 && m_prev[p] == 0 && m_mask[p] == 0) begin
            edge_seen = 1;
            m_mask[p] = 1;
          end else if (mask_clr[p]) begin
            m_mask[p] = 0;
          end
          m_prev[p] = lvl[p];
          void'(hist[p].pop_back());
          hist[p].push_front(int'(ext_pin[p]));
        end
        if (entry) begin
          if (m_in != 0) m_in = 0;
          else m_tm = 0;
          m_ie = 0;
        end else if (ret || ie_set) begin
          m_ie = 1;
        end
        if (edge_seen) m_in = 1;
        if (timer_req) m_tm = 1;
      end
      rs2 = rs1;
      rs1 = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_take;
      int exp_vec;
      exp_take = (m_ie != 0) && (m_in != 0 || m_tm != 0);
      exp_vec  = (m_in != 0) ? 'h07F : 'h03F;
      chk(int'(take) == exp_take, "R5 take_o", int'(take), exp_take);
      if (exp_take != 0) chk(int'(vec) == exp_vec, "R8 vec_o", int'(vec), exp_vec);
      chk(int'(ie) == m_ie, "R9 ie_o", int'(ie), m_ie);
      chk(int'(mask) == (m_mask[1]*2 + m_mask[0]), "R3 mask_o", int'(mask), m_mask[1]*2 + m_mask[0]);
      chk(int'(pin_lvl) == (hist[1][1]*2 + hist[0][1]), "R10 pin_lvl_o", int'(pin_lvl), hist[1][1]*2 + hist[0][1]);
      if (take) begin
        if (vec == 10'h07F) n_in++;
        else n_tm++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ret();
    ret = 1'b1; cyc(1); ret = 1'b0;
  endtask

  task automatic pulse_ie();
    ie_set = 1'b1; cyc(1); ie_set = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    mask_clr = m; cyc(1); mask_clr = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    // R1: reset state
    chk(mask == 2'b11 && !ie && !take, "R1 reset", int'({mask, ie, take}), 'hC);

    // R2: unmasked rising edge is taken with pin vector
    pulse_clr(2'b01);
    pulse_ie();
    ext_pin[0] = 1'b1;
    cyc(6);
    chk(n_in == 1, "R2 pin entry count", n_in, 1);
    chk(mask[0] == 1'b1, "R2 mask armed", int'(mask[0]), 1);
    pulse_ret();
    cyc(2);

    // R3: edges while masked are ignored
    ext_pin[0] = 1'b0; cyc(3);
    ext_pin[0] = 1'b1; cyc(6);
    chk(n_in == 1, "R3 masked edge", n_in, 1);
    pulse_clr(2'b01);
    ext_pin[0] = 1'b0; cyc(4);
    ext_pin[0] = 1'b1; cyc(6);
    chk(n_in == 2, "R3 after unmask", n_in, 2);
    pulse_ret();
    cyc(2);

    // R4: falling edge creates nothing
    pulse_clr(2'b01);
    ext_pin[0] = 1'b0; cyc(8);
    chk(n_in == 2, "R4 falling edge", n_in, 2);
    chk(mask[0] == 1'b0, "R4 mask stays clear", int'(mask[0]), 0);

    // R11: timer pulse taken with timer vector
    timer_req = 1'b1; cyc(1); timer_req = 1'b0;
    cyc(3);
    chk(n_tm == 1, "R11 timer entry", n_tm, 1);

    // R6: enable is now 0, pin request held
    pulse_clr(2'b10);
    ext_pin[1] = 1'b1; cyc(10);
    chk(n_in == 2, "R6 held while disabled", n_in, 2);
    pulse_ie();
    cyc(2);
    chk(n_in == 3, "R6 taken after enable", n_in, 3);

    // R7: both pending, pin first, timer after return
    pulse_clr(2'b11);
    ext_pin[1] = 1'b0;
    cyc(3);
    ext_pin[0] = 1'b1;
    timer_req = 1'b1; cyc(1); timer_req = 1'b0;
    cyc(6);
    chk(n_in == 3 && n_tm == 1, "R7 nothing while disabled", n_in * 16 + n_tm, 'h31);
    pulse_ie();
    cyc(4);
    chk(n_in == 4, "R7 pin served first", n_in, 4);
    chk(n_tm == 1, "R7 timer waits", n_tm, 1);
    pulse_ret();
    cyc(3);
    chk(n_tm == 2, "R7 timer after return", n_tm, 2);
    chk(ie == 1'b0, "R9 enable dropped by entry", int'(ie), 0);

    cyc(4);
    finish_run();
  end

endmodule